// File: doc/BRIEF.md
# SPI Master/Slave Serial Port

This block is a synchronous serial port that runs as either the clock-driving master or the clock-following slave of an SPI link. A processor-side register interface writes bytes into an 8-bit shift register and reads completed bytes from a separate receive buffer. Serial data leaves and enters most-significant bit first, one bit per selected serial-clock edge. The block also drives output-enables for the serial clock and data-out pins.

A 4-bit mode field chooses the role and the clock source. As master, the serial clock is derived from the system clock, which stands for the instruction clock, divided by one of three prescaler settings. It can also be derived from a timer pulse input, with every second pulse counted. As slave, the port either ignores the active-low select input, or uses it to frame transfers: a high select line clears the bit counter and floats data-out. Separate control bits set the idle clock level and pick which clock edge shifts. A global enable gates everything. The intended way to reconfigure the port is to clear the enable, change the mode, then set it again.

Top module: `spi_port`

## Requirements
- R1: While `cfgEnable` is 0, `sckOe` and `sdoOe` are 0, and `bufFull`, `overflow`, `writeCollide` and `irqPulse` are cleared on the next clock edge. Bus writes have no effect in this state.
- R2: In master modes (`cfgMode` 4'b0000, 4'b0001, 4'b0010, 4'b0011), a bus write while idle loads the shift register and starts an 8-bit transfer. `sdo` is the shift register MSB. Each shift moves `sdi` in at the LSB, so when `sdi` is looped back to `sdo` the received byte equals the sent byte.
- R3: With the prescaler modes 4'b0000, 4'b0001 and 4'b0010, the serial clock toggles once every N system clocks, with N = 4, 16 or 64. `bufFull` becomes 1 exactly 16*N clock edges after the edge that samples the starting write.
- R4: In mode 4'b0011, the serial clock toggles once for every second `timerTick` pulse. A transfer completes on the 32nd pulse and makes no progress without pulses.
- R5: `sckOut` equals `cfgPol` whenever the master is not transferring. `sckOe` is 1 in master modes and 0 in slave modes.
- R6: `cfgEdge` = 0 shifts on the leading edge of the serial clock (the change away from the `cfgPol` level). `cfgEdge` = 1 shifts on the trailing edge (the return to `cfgPol`).
- R7: When the 8th bit has shifted, the shift register is copied to `rdData`, `bufFull` is set and `irqPulse` is high for exactly one cycle. A `busRead` pulse clears `bufFull`.
- R8: If a byte completes while `bufFull` is 1 and no read is in the same cycle, `rdData` keeps its old value and `overflow` is set.
- R9: A bus write while a transfer is in progress sets `writeCollide` and does not alter the byte being shifted.
- R10: Mode 4'b0101 is slave mode with `selN` ignored. The shift register shifts on edges of `sckIn`, `sdoOe` is 1, and 8 shifts complete a byte as in R7.
- R11: Mode 4'b0100 is slave mode framed by `selN`. While `selN` is 1, `sdoOe` is 0, the bit counter is held at zero and clock edges shift nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (instruction clock) |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgEnable | input | 1 | Global port enable |
| cfgMode | input | 4 | Role and clock source select |
| cfgEdge | input | 1 | Shift edge select: 0 leading, 1 trailing |
| cfgPol | input | 1 | Idle level of the serial clock |
| timerTick | input | 1 | Single-cycle timer pulse for the timer clock mode |
| busWrite | input | 1 | Write strobe for the transmit byte |
| busWdata | input | 8 | Byte to transmit |
| busRead | input | 1 | Read strobe, clears the buffer-full flag |
| rdData | output | 8 | Receive buffer contents |
| bufFull | output | 1 | Receive buffer holds an unread byte |
| overflow | output | 1 | A byte was lost because the buffer was full |
| writeCollide | output | 1 | A write arrived during a transfer |
| irqPulse | output | 1 | One-cycle pulse on byte completion |
| sckIn | input | 1 | Serial clock from the link (slave) |
| sckOut | output | 1 | Serial clock to the link (master) |
| sckOe | output | 1 | Output-enable for the serial clock pin |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdoOe | output | 1 | Output-enable for the data-out pin |
| selN | input | 1 | Active-low slave select |

## Verification
The assertions assume that `sckIn`, `sdi` and `selN` are already synchronous to `clk` and hold each level for at least two cycles. They also assume that `timerTick` is a single-cycle pulse, that `cfgMode`, `cfgEdge` and `cfgPol` change only while `cfgEnable` is 0, and that trailing-edge slave operation is used only with select framing. The stimulus changes every input on the falling clock edge and keeps each serial clock level for two system cycles. It reconfigures only through a disable–modify–enable sequence and sets the idle clock level before enabling a slave mode, so no false edge is seen.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic clear;   // port disabled: drop flags
    logic load;    // bus byte into the shift register
    logic shift;   // move one serial bit
    logic finish;  // byte complete this cycle
  } strobe_t;

  localparam logic [3:0] MODE_DIV_A    = 4'b0000;
  localparam logic [3:0] MODE_DIV_B    = 4'b0001;
  localparam logic [3:0] MODE_DIV_C    = 4'b0010;
  localparam logic [3:0] MODE_TIMER    = 4'b0011;
  localparam logic [3:0] MODE_SLV_SEL  = 4'b0100;
  localparam logic [3:0] MODE_SLV_FREE = 4'b0101;

endpackage

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_A  = 4,
  parameter int DIV_B  = 16,
  parameter int DIV_C  = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgEnable,
  input  logic [3:0] cfgMode,
  input  logic       cfgEdge,
  input  logic       cfgPol,
  input  logic       timerTick,
  input  logic       busWrite,
  input  logic       sckIn,
  input  logic       selN,
  output strobe_t    strobes,
  output logic       sckOut,
  output logic       sckOe,
  output logic       sdoOe,
  output logic       writeCollide
);

  localparam int PRE_AB  = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int PRE_MAX = (PRE_AB > DIV_C) ? PRE_AB : DIV_C;
  localparam int PRE_W   = (PRE_MAX > 2) ? $clog2(PRE_MAX) : 1;
  localparam int TOG_N   = 2 * DATA_W;
  localparam int TOG_W   = $clog2(TOG_N);
  localparam int BIT_W   = $clog2(DATA_W);

  logic             isMaster, isSlave, deselect;
  logic [PRE_W-1:0] divLimit, preCnt;
  logic [TOG_W-1:0] togCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             mBusy, sckReg, tmrHalf, sckPrev;
  logic             busy, start, mTick, mShift, mDone;
  logic             sEdge, sLead, sShift, sDone;

  // Mode decode
  always_comb begin
    isMaster = cfgEnable && (cfgMode == MODE_DIV_A || cfgMode == MODE_DIV_B ||
                             cfgMode == MODE_DIV_C || cfgMode == MODE_TIMER);
    isSlave  = cfgEnable && (cfgMode == MODE_SLV_SEL || cfgMode == MODE_SLV_FREE);
    deselect = isSlave && (cfgMode == MODE_SLV_SEL) && selN;
    case (cfgMode)
      MODE_DIV_A: divLimit = PRE_W'(DIV_A - 1);
      MODE_DIV_B: divLimit = PRE_W'(DIV_B - 1);
      default:    divLimit = PRE_W'(DIV_C - 1);
    endcase
  end

  // Tick, edge and strobe generation
  always_comb begin
    busy  = mBusy || (bitCnt != '0);
    start = busWrite && isMaster && !mBusy;
    if (cfgMode == MODE_TIMER) mTick = mBusy && timerTick && tmrHalf;
    else                       mTick = mBusy && (preCnt == divLimit);
    mShift = mTick && ((sckReg == cfgPol) ? !cfgEdge : cfgEdge);
    mDone  = mTick && (togCnt == TOG_W'(TOG_N - 1));

    sEdge  = (sckIn != sckPrev);
    sLead  = (sckIn != cfgPol);
    sShift = isSlave && !deselect && sEdge && (sLead ? !cfgEdge : cfgEdge);
    sDone  = sShift && (bitCnt == BIT_W'(DATA_W - 1));

    strobes.clear  = !cfgEnable;
    strobes.load   = busWrite && !busy && (isMaster || isSlave);
    strobes.shift  = mShift || sShift;
    strobes.finish = mDone || sDone;
  end

  // Master clock generator and transfer sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy   <= 1'b0;
      togCnt  <= '0;
      preCnt  <= '0;
      tmrHalf <= 1'b0;
      sckReg  <= 1'b0;
    end else if (!isMaster || start) begin
      mBusy   <= start;
      togCnt  <= '0;
      preCnt  <= '0;
      tmrHalf <= 1'b0;
      sckReg  <= cfgPol;
    end else if (mBusy) begin
      if (cfgMode == MODE_TIMER) begin
        if (timerTick) tmrHalf <= ~tmrHalf;
      end else begin
        preCnt <= (preCnt == divLimit) ? '0 : preCnt + 1'b1;
      end
      if (mTick) begin
        sckReg <= ~sckReg;
        togCnt <= togCnt + 1'b1;
        if (mDone) mBusy <= 1'b0;
      end
    end
  end

  // Slave bit counter, clock edge history and collision flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt       <= '0;
      sckPrev      <= 1'b0;
      writeCollide <= 1'b0;
    end else begin
      sckPrev <= sckIn;
      if (!isSlave || deselect) bitCnt <= '0;
      else if (sShift)          bitCnt <= sDone ? '0 : bitCnt + 1'b1;
      if (!cfgEnable)           writeCollide <= 1'b0;
      else if (busWrite && busy) writeCollide <= 1'b1;
    end
  end

  always_comb begin
    sckOut = (isMaster && mBusy) ? sckReg : cfgPol;
    sckOe  = isMaster;
    sdoOe  = isMaster || (isSlave && !deselect);
  end

endmodule

// File: rtl/spi_port_dpath.sv
module spi_port_dpath
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic              busRead,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              sdi,
  output logic              sdo,
  output logic [DATA_W-1:0] rdData,
  output logic              bufFull,
  output logic              overflow,
  output logic              irqPulse
);

  logic [DATA_W-1:0] shReg, nextSh;

  always_comb begin
    nextSh = strobes.shift ? {shReg[DATA_W-2:0], sdi} : shReg;
    sdo    = shReg[DATA_W-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shReg <= '0;
    else if (strobes.load) shReg <= busWdata;
    else shReg <= nextSh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData   <= '0;
      bufFull  <= 1'b0;
      overflow <= 1'b0;
      irqPulse <= 1'b0;
    end else if (strobes.clear) begin
      bufFull  <= 1'b0;
      overflow <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      irqPulse <= strobes.finish;
      if (strobes.finish) begin
        if (bufFull && !busRead) begin
          overflow <= 1'b1;
        end else begin
          rdData  <= nextSh;
          bufFull <= 1'b1;
        end
      end else if (busRead) begin
        bufFull <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_A  = 4,
  parameter int DIV_B  = 16,
  parameter int DIV_C  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic [3:0]        cfgMode,
  input  logic              cfgEdge,
  input  logic              cfgPol,
  input  logic              timerTick,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRead,
  output logic [DATA_W-1:0] rdData,
  output logic              bufFull,
  output logic              overflow,
  output logic              writeCollide,
  output logic              irqPulse,
  input  logic              sckIn,
  output logic              sckOut,
  output logic              sckOe,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdoOe,
  input  logic              selN
);

  strobe_t strobes;

  spi_port_ctrl #(
    .DATA_W(DATA_W), .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgMode(cfgMode),
    .cfgEdge(cfgEdge), .cfgPol(cfgPol), .timerTick(timerTick),
    .busWrite(busWrite), .sckIn(sckIn), .selN(selN), .strobes(strobes),
    .sckOut(sckOut), .sckOe(sckOe), .sdoOe(sdoOe), .writeCollide(writeCollide)
  );

  spi_port_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busRead(busRead),
    .busWdata(busWdata), .sdi(sdi), .sdo(sdo), .rdData(rdData),
    .bufFull(bufFull), .overflow(overflow), .irqPulse(irqPulse)
  );

endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgEnable,
  input logic [3:0]        cfgMode,
  input logic              busRead,
  input logic              selN,
  input logic              sckOe,
  input logic              sdoOe,
  input logic              bufFull,
  input logic              irqPulse,
  input logic              writeCollide,
  input logic [DATA_W-1:0] rdData
);

  p_oe_off_disabled_r1: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |-> (!sckOe && !sdoOe));

  p_sck_oe_master_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && cfgMode[3:2] == 2'b00) |-> sckOe);

  p_sck_oe_slave_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && (cfgMode == 4'b0100 || cfgMode == 4'b0101)) |-> !sckOe);

  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  p_irq_with_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> bufFull);

  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && bufFull && busRead) |=> (!bufFull || irqPulse));

  p_no_overwrite_r8: assert property (@(posedge clk) disable iff (!rstN)
    (bufFull && !busRead) |=> $stable(rdData));

  p_collide_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && writeCollide) |=> writeCollide);

  p_sdo_float_desel_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && cfgMode == 4'b0100 && selN) |-> !sdoOe);

endmodule

bind spi_port spi_port_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgMode(cfgMode),
  .busRead(busRead), .selN(selN), .sckOe(sckOe), .sdoOe(sdoOe),
  .bufFull(bufFull), .irqPulse(irqPulse), .writeCollide(writeCollide),
  .rdData(rdData)
);

// File: tb/spi_port_tb_top.sv
module spi_port_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgEnable = 1'b0;
  logic [3:0] cfgMode = 4'b0000;
  logic       cfgEdge = 1'b0;
  logic       cfgPol = 1'b0;
  logic       timerTick = 1'b0;
  logic       busWrite = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic       busRead = 1'b0;
  logic [7:0] rdData;
  logic       bufFull, overflow, writeCollide, irqPulse;
  logic       sckDrv = 1'b0;
  logic       sckOut, sckOe;
  logic       sdiDrv = 1'b0;
  logic       loopOn = 1'b0;
  logic       sdi, sdo, sdoOe;
  logic       selN = 1'b1;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  assign sdi = loopOn ? sdo : sdiDrv;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_port dut_i (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgMode(cfgMode),
    .cfgEdge(cfgEdge), .cfgPol(cfgPol), .timerTick(timerTick),
    .busWrite(busWrite), .busWdata(busWdata), .busRead(busRead),
    .rdData(rdData), .bufFull(bufFull), .overflow(overflow),
    .writeCollide(writeCollide), .irqPulse(irqPulse), .sckIn(sckDrv),
    .sckOut(sckOut), .sckOe(sckOe), .sdi(sdi), .sdo(sdo), .sdoOe(sdoOe),
    .selN(selN)
  );

  // Master vectors: {mode, edge, pol, pad, data}
  localparam logic [15:0] MVEC [4] = '{
    {4'd0, 1'b0, 1'b0, 2'b00, 8'hA5},
    {4'd1, 1'b1, 1'b0, 2'b00, 8'h3C},
    {4'd2, 1'b0, 1'b1, 2'b00, 8'h81},
    {4'd0, 1'b1, 1'b1, 2'b00, 8'h7E}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic configure(input logic [3:0] m, input logic e, input logic p);
    @(negedge clk) cfgEnable = 1'b0;
    @(negedge clk) begin cfgMode = m; cfgEdge = e; cfgPol = p; sckDrv = p; end
    @(negedge clk) cfgEnable = 1'b1;
    @(negedge clk);
  endtask

  task automatic busWr(input logic [7:0] b);
    @(negedge clk) begin busWrite = 1'b1; busWdata = b; end
    @(negedge clk) busWrite = 1'b0;
  endtask

  task automatic busRd();
    @(negedge clk) busRead = 1'b1;
    @(negedge clk) busRead = 1'b0;
  endtask

  // Master transfer: returns edges from the write edge until irqPulse.
  task automatic mxfer(input logic [7:0] b, output int n);
    busWr(b);
    n = 0;
    while (!irqPulse && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // One slave bit; returns sdo seen before the leading edge.
  task automatic sbit(input logic b, output logic seen);
    @(negedge clk) begin sdiDrv = b; seen = sdo; end
    @(negedge clk) sckDrv = ~cfgPol;
    repeat (2) @(negedge clk);
    sckDrv = cfgPol;
    repeat (2) @(negedge clk);
  endtask

  task automatic sbyte(input logic [7:0] tx, output logic [7:0] seenBits);
    for (int i = 7; i >= 0; i--) begin
      logic s;
      sbit(tx[i], s);
      seenBits[i] = s;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=done", WATCHDOG);
    summary();
  end

  initial begin
    int n;
    logic [7:0] seen;
    logic s;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // Reset state
    chk("R1 reset bufFull", bufFull, 0);
    chk("R1 reset overflow", overflow, 0);
    chk("R1 reset writeCollide", writeCollide, 0);
    chk("R1 reset oe", {sckOe, sdoOe}, 0);
    chk("R7 reset rdData", rdData, 8'h00);

    // Table of master loopback transfers
    loopOn = 1'b1;
    for (int v = 0; v < 4; v++) begin
      logic [3:0] m;
      logic [7:0] d;
      int divN;
      m = MVEC[v][15:12];
      d = MVEC[v][7:0];
      divN = (m == 4'd0) ? 4 : (m == 4'd1) ? 16 : 64;
      configure(m, MVEC[v][11], MVEC[v][10]);
      chk("R5 master sckOe", sckOe, 1);
      chk("R5 idle sck before", sckOut, MVEC[v][10]);
      mxfer(d, n);
      chk("R3 transfer length", n, 16 * divN);
      chk("R2 loopback data", rdData, d);
      chk("R7 bufFull set", bufFull, 1);
      @(negedge clk);
      chk("R7 irq one cycle", irqPulse, 0);
      chk("R5 idle sck after", sckOut, MVEC[v][10]);
      busRd();
      chk("R7 read clears bufFull", bufFull, 0);
    end

    // Timer clock mode, with a collision during the transfer
    configure(4'd3, 1'b0, 1'b0);
    busWr(8'h5A);
    repeat (100) @(negedge clk);
    chk("R4 no progress without ticks", bufFull, 0);
    chk("R4 sck idle without ticks", sckOut, 0);
    busWr(8'hFF);
    chk("R9 collision flag", writeCollide, 1);
    for (int t = 0; t < 31; t++) begin
      @(negedge clk) timerTick = 1'b1;
      @(negedge clk) timerTick = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk("R4 not done after 31 ticks", bufFull, 0);
    @(negedge clk) timerTick = 1'b1;
    @(negedge clk) timerTick = 1'b0;
    chk("R4 done on 32nd tick", bufFull, 1);
    chk("R9 collided write ignored", rdData, 8'h5A);

    // Overflow
    configure(4'd0, 1'b0, 1'b0);
    chk("R1 disable clears collide", writeCollide, 0);
    mxfer(8'h22, n);
    mxfer(8'h11, n);
    @(negedge clk);
    chk("R8 overflow set", overflow, 1);
    chk("R8 buffer kept", rdData, 8'h22);
    @(negedge clk) cfgEnable = 1'b0;
    @(negedge clk);
    chk("R1 disable clears flags", {overflow, bufFull}, 0);
    chk("R1 disable oe off", {sckOe, sdoOe}, 0);
    busWr(8'h99);
    chk("R1 write ignored when off", writeCollide, 0);
    loopOn = 1'b0;

    // Slave, select ignored
    selN = 1'b1;
    configure(4'd5, 1'b0, 1'b0);
    chk("R10 slave sdoOe", sdoOe, 1);
    chk("R5 slave sckOe", sckOe, 0);
    busWr(8'hC3);
    sbyte(8'h96, seen);
    @(negedge clk);
    chk("R10 slave rx", rdData, 8'h96);
    chk("R10 slave bufFull", bufFull, 1);
    chk("R10 slave tx bits", seen, 8'hC3);
    busRd();

    // Edge select: trailing edge, idle high
    configure(4'd4, 1'b1, 1'b1);
    selN = 1'b0;
    busWr(8'h80);
    @(negedge clk) sdiDrv = 1'b0;
    @(negedge clk) sckDrv = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 no shift on leading", sdo, 1);
    sckDrv = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 shift on trailing", sdo, 0);
    for (int i = 0; i < 7; i++) sbit(1'b1, s);
    @(negedge clk);
    chk("R6 trailing rx", rdData, 8'h7F);
    busRd();

    // Select framing
    selN = 1'b1;
    configure(4'd4, 1'b0, 1'b0);
    chk("R11 sdo floats deselected", sdoOe, 0);
    for (int i = 0; i < 3; i++) sbit(1'b1, s);
    @(negedge clk) selN = 1'b0;
    @(negedge clk);
    chk("R11 sdo driven selected", sdoOe, 1);
    sbit(1'b0, s); sbit(1'b1, s); sbit(1'b0, s);
    @(negedge clk) selN = 1'b1;
    repeat (2) @(negedge clk);
    selN = 1'b0;
    sbyte(8'hA7, seen);
    @(negedge clk);
    chk("R11 count reset on deselect", rdData, 8'hA7);
    chk("R11 framed byte complete", bufFull, 1);

    summary();
  end

endmodule